// File: doc/BRIEF.md
# Sub-pipelined AES-128 Encryption Core

This block encrypts a stream of 128-bit blocks with AES-128. It takes one plaintext block per clock and, once full, returns one ciphertext block per clock. All ten rounds are unrolled in hardware. Each round is cut into three registered substages, and an extra register sits at every round entry.

The S-box is built from logic rather than a lookup table. It computes the field inverse by exponentiation, then applies the affine map. Because it is logic, the inverse can be split across two register stages. The third substage does the byte rotation, the column mixing and the key XOR.

The eleven round keys come in on one wide bus, produced elsewhere and held steady while blocks are in flight. A valid flag travels with each block. There is no stall and no backpressure.

Top module: `aes128_subpipe_enc`

## Requirements
- R1: Before the first round, the input block is XORed with round key 0. Round key i sits on `round_keys` bits [128*i+127 : 128*i], and each AddRoundKey is a plain bitwise XOR.
- R2: SubBytes maps each byte to the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0, followed by the affine map b ^ rotl1(b) ^ rotl2(b) ^ rotl3(b) ^ rotl4(b) ^ 0x63. So a zero byte becomes 0x63.
- R3: ShiftRows keeps state row 0 and rotates rows 1, 2 and 3 left by 1, 2 and 3 byte positions.
- R4: In rounds 1 to 9, MixColumns multiplies each column by the circulant matrix whose first row is 02 03 01 01. Doubling is a left shift, followed by XOR with 0x1B when the bit shifted out was 1.
- R5: Round 10 omits MixColumns. It applies only SubBytes, ShiftRows and AddRoundKey, using round key 10.
- R6: A block presented with `in_valid` high before clock edge E appears on `out_block` with `out_valid` high right after edge E+39. That is 40 cycles, equal to 10*3+10.
- R7: Blocks presented on consecutive cycles leave on consecutive cycles, in order, with no gap.
- R8: `out_valid` repeats `in_valid` delayed by exactly 40 cycles, including any gaps. While reset is asserted, and for the first 40 cycles after it, `out_valid` is 0.
- R9: Byte 0 of a block is bits [127:120]. Bytes fill the 4x4 state column by column, so byte n is row n%4, column n/4.
- R10: When `in_valid` is 0, `in_block` is ignored. `out_block` keeps the last ciphertext it showed for as long as `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks `in_block` as a block to encrypt this cycle |
| in_block | input | 128 | Plaintext block, byte 0 in the top bits |
| round_keys | input | 1408 | Eleven round keys, key i at bits [128*i+127 : 128*i] |
| out_valid | output | 1 | Marks `out_block` as a fresh ciphertext |
| out_block | output | 128 | Ciphertext block, same byte order as the input |

## Verification
The bench builds the core with its default of ten rounds, which gives the 40-cycle pipeline of a real AES-128 instance. With this build, published answer vectors can be compared bit for bit, covering the zero-byte S-box case and the last round without column mixing. The exact edge at which each result emerges can also be checked. Streams with gaps and back-to-back runs cover the valid timing. Garbage presented on idle cycles covers the hold behaviour.

// File: rtl/aes_pipe_pkg.sv
package aes_pipe_pkg;

  localparam int BLK_W          = 128;
  localparam int NBYTES         = BLK_W / 8;
  localparam int SUBSTAGES      = 3;
  localparam int REGS_PER_ROUND = SUBSTAGES + 1;

  typedef logic [7:0]       byte_t;
  typedef logic [BLK_W-1:0] block_t;

  function automatic byte_t gf_dbl(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  function automatic byte_t gf_sq(byte_t a);
    return gf_mul(a, a);
  endfunction

  // First half of the inverse: returns {x^15, x^14}
  function automatic logic [15:0] inv_front(byte_t x);
    byte_t p2, p3, p12, p14, p15;
    p2  = gf_sq(x);
    p3  = gf_mul(p2, x);
    p12 = gf_sq(gf_sq(p3));
    p15 = gf_mul(p12, p3);
    p14 = gf_mul(p12, p2);
    return {p15, p14};
  endfunction

  // Second half: x^254 = (x^15)^16 * x^14, then the affine map
  function automatic byte_t inv_back(logic [15:0] pr);
    byte_t t, iv;
    t  = pr[15:8];
    for (int i = 0; i < 4; i++) t = gf_sq(t);
    iv = gf_mul(t, pr[7:0]);
    return iv ^ {iv[6:0], iv[7]} ^ {iv[5:0], iv[7:6]} ^
           {iv[4:0], iv[7:5]} ^ {iv[3:0], iv[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t get_b(block_t blk, int n);
    return blk[8*(NBYTES-1-n) +: 8];
  endfunction

  function automatic block_t shift_rows(block_t s);
    block_t o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[8*(NBYTES-1-(r+4*c)) +: 8] = get_b(s, r + 4*((c+r)%4));
    return o;
  endfunction

  function automatic block_t mix_columns(block_t s);
    block_t o;
    byte_t a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = get_b(s, 4*c);
      a1 = get_b(s, 4*c+1);
      a2 = get_b(s, 4*c+2);
      a3 = get_b(s, 4*c+3);
      o[8*(NBYTES-1-4*c)   +: 8] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
      o[8*(NBYTES-2-4*c)   +: 8] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
      o[8*(NBYTES-3-4*c)   +: 8] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
      o[8*(NBYTES-4-4*c)   +: 8] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
    end
    return o;
  endfunction

endpackage

// File: rtl/aes_inv_front.sv
module aes_inv_front
  import aes_pipe_pkg::*;
(
  input  block_t               state_i,
  output logic [2*BLK_W-1:0]   pair_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign pair_o[16*b +: 16] = inv_front(state_i[8*b +: 8]);
  end
endmodule

// File: rtl/aes_inv_back.sv
module aes_inv_back
  import aes_pipe_pkg::*;
(
  input  logic [2*BLK_W-1:0] pair_i,
  output block_t             state_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign state_o[8*b +: 8] = inv_back(pair_i[16*b +: 16]);
  end
endmodule

// File: rtl/aes_mix_tail.sv
module aes_mix_tail
  import aes_pipe_pkg::*;
#(
  parameter bit FINAL = 1'b0
)(
  input  block_t state_i,
  input  block_t rkey_i,
  output block_t state_o
);
  if (FINAL) begin : g_last
    always_comb state_o = shift_rows(state_i) ^ rkey_i;
  end else begin : g_full
    always_comb state_o = mix_columns(shift_rows(state_i)) ^ rkey_i;
  end
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_pipe_pkg::*;
#(
  parameter bit FINAL = 1'b0
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  block_t                    in_state,
  input  block_t                    rkey,
  output logic                      out_vld,
  output block_t                    out_state,
  output logic [REGS_PER_ROUND-1:0] stg_vld
);
  logic [REGS_PER_ROUND-1:0] vld_q, vld_d;
  block_t                    ent_q, ent_d;
  logic [2*BLK_W-1:0]        half_q, half_d, half_c;
  block_t                    sub_q, sub_d, sub_c;
  block_t                    res_q, res_d, res_c;

  aes_inv_front u_front (.state_i(ent_q), .pair_o(half_c));
  aes_inv_back  u_back  (.pair_i(half_q), .state_o(sub_c));
  aes_mix_tail #(.FINAL(FINAL)) u_tail (
    .state_i(sub_q), .rkey_i(rkey), .state_o(res_c));

  // next state with explicit per-stage load enables
  always_comb begin
    vld_d  = {vld_q[REGS_PER_ROUND-2:0], in_vld};
    ent_d  = in_vld   ? in_state : ent_q;
    half_d = vld_q[0] ? half_c   : half_q;
    sub_d  = vld_q[1] ? sub_c    : sub_q;
    res_d  = vld_q[2] ? res_c    : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    ent_q  <= ent_d;
    half_q <= half_d;
    sub_q  <= sub_d;
    res_q  <= res_d;
  end

  assign out_vld   = vld_q[REGS_PER_ROUND-1];
  assign out_state = res_q;
  assign stg_vld   = vld_q;
endmodule

// File: rtl/aes128_subpipe_enc.sv
module aes128_subpipe_enc
  import aes_pipe_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [BLK_W-1:0]                 in_block,
  input  logic [(NUM_ROUNDS+1)*BLK_W-1:0]  round_keys,
  output logic                             out_valid,
  output logic [BLK_W-1:0]                 out_block
);
  localparam int LATENCY = NUM_ROUNDS * REGS_PER_ROUND;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                vld_c [NUM_ROUNDS+1];
  block_t              dat_c [NUM_ROUNDS+1];
  logic [LATENCY-1:0]  pipe_vld;

  assign vld_c[0] = in_valid;
  assign dat_c[0] = in_block ^ round_keys[BLK_W-1:0];

  for (genvar i = 1; i <= NUM_ROUNDS; i++) begin : g_round
    aes_round_unit #(.FINAL(i == NUM_ROUNDS)) u_round (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .in_vld   (vld_c[i-1]),
      .in_state (dat_c[i-1]),
      .rkey     (round_keys[BLK_W*i +: BLK_W]),
      .out_vld  (vld_c[i]),
      .out_state(dat_c[i]),
      .stg_vld  (pipe_vld[(i-1)*REGS_PER_ROUND +: REGS_PER_ROUND])
    );
  end

  assign out_valid = vld_c[NUM_ROUNDS];
  assign out_block = dat_c[NUM_ROUNDS];
endmodule

// File: rtl/aes128_subpipe_enc_chk.sv
module aes128_subpipe_enc_chk #(
  parameter int LATENCY = 40
)(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [127:0]       out_block,
  input logic [LATENCY-1:0] pipe_vld
);
  localparam int AW = $clog2(LATENCY + 1);

  logic [AW-1:0]      age_q;
  logic [LATENCY-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (age_q != AW'(LATENCY)) age_q <= age_q + AW'(1);
      shadow_q <= {shadow_q[LATENCY-2:0], in_valid};
    end
  end

  // R6: a flag entering the pipe leaves exactly LATENCY cycles later
  a_r6_exit_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == shadow_q[LATENCY-1]);

  // R6: entry register samples the input flag
  a_r6_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != '0) |-> (pipe_vld[0] == $past(in_valid)));

  // R7: each stage hands its flag on one cycle later
  for (genvar k = 1; k < LATENCY; k++) begin : g_adv
    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != '0) |-> (pipe_vld[k] == $past(pipe_vld[k-1])));
  end

  // R8: nothing valid before the pipe could have filled
  a_r8_quiet_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < AW'(LATENCY)) |-> !out_valid);

  // R10: output data holds while no valid result arrives
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q != '0) && !out_valid) |-> $stable(out_block));
endmodule

bind aes128_subpipe_enc aes128_subpipe_enc_chk #(.LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_block(out_block),
  .pipe_vld (pipe_vld)
);

// File: tb/test_aes128_subpipe_enc.sv
module test_aes128_subpipe_enc;
  localparam int LAT = 10*3 + 10;
  localparam int KW  = 11*128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [127:0]    in_block = '0;
  logic [KW-1:0]   round_keys = '0;
  logic            out_valid;
  logic [127:0]    out_block;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  aes128_subpipe_enc i_aes128_subpipe_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .round_keys(round_keys), .out_valid(out_valid), .out_block(out_block));

  // ---------------- reference model ----------------
  logic [7:0] sb_ref [256];

  function automatic logic [7:0] rmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotb(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (rmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      sb_ref[x] = iv ^ rotb(iv,1) ^ rotb(iv,2) ^ rotb(iv,3) ^ rotb(iv,4) ^ 8'h63;
    end
  endtask

  function automatic logic [KW-1:0] expand_key(logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    logic [KW-1:0] bus;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb_ref[t[31:24]], sb_ref[t[23:16]], sb_ref[t[15:8]], sb_ref[t[7:0]]}
            ^ {rc, 24'h0};
        rc = rmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int j = 0; j < 11; j++)
      bus[128*j +: 128] = {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]};
    return bus;
  endfunction

  function automatic logic [127:0] ref_enc(logic [127:0] pt, logic [KW-1:0] rk);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] k, o;
    for (int n = 0; n < 16; n++) s[n] = pt[127-8*n -: 8] ^ rk[127-8*n -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int n = 0; n < 16; n++) s[n] = sb_ref[s[n]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[r+4*c] = s[r + 4*((c+r)%4)];
      for (int c = 0; c < 4; c++) begin
        if (rd < 10) begin
          for (int r = 0; r < 4; r++)
            s[4*c+r] = rmul(t[4*c+r], 8'h02) ^ rmul(t[4*c+(r+1)%4], 8'h03)
                     ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
        end else begin
          for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
        end
      end
      k = rk[128*rd +: 128];
      for (int n = 0; n < 16; n++) s[n] = s[n] ^ k[127-8*n -: 8];
    end
    for (int n = 0; n < 16; n++) o[127-8*n -: 8] = s[n];
    return o;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [127:0] seq_dat [64];
  bit           seq_vld [64];
  int           seq_len;
  logic [127:0] last_ct;

  // drives seq_* back to back; checks every output cycle at the negedge
  task automatic run_seq(string req);
    for (int c = 0; c < seq_len + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        check(out_valid == seq_vld[c-LAT], {req, " valid"},
              128'(out_valid), 128'(seq_vld[c-LAT]));
        if (seq_vld[c-LAT]) begin
          last_ct = ref_enc(seq_dat[c-LAT], round_keys);
          check(out_block == last_ct, {req, " data"}, out_block, last_ct);
        end
      end else begin
        check(out_valid == 1'b0, {req, " R6 early"}, 128'(out_valid), 128'(0));
      end
      if (c < seq_len) begin
        in_valid = seq_vld[c];
        in_block = seq_dat[c];
      end else begin
        in_valid = 1'b0;
        in_block = ~in_block;
      end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8 after reset", 128'(out_valid), 128'(0));
  endtask

  task automatic t_known(logic [127:0] key, logic [127:0] pt, logic [127:0] ct,
                         string req);
    round_keys = expand_key(key);
    check(ref_enc(pt, round_keys) == ct, {req, " model"}, ref_enc(pt, round_keys), ct);
    @(negedge clk);
    in_valid = 1'b1;
    in_block = pt;
    @(negedge clk);
    in_valid = 1'b0;
    in_block = '0;
    repeat (LAT - 2) @(negedge clk);
    check(out_valid == 1'b0, {req, " R6 edge-39"}, 128'(out_valid), 128'(0));
    @(negedge clk);
    check(out_valid == 1'b1, {req, " R6 edge-40"}, 128'(out_valid), 128'(1));
    check(out_block == ct, req, out_block, ct);
    @(negedge clk);
    check(out_valid == 1'b0, {req, " R8 single"}, 128'(out_valid), 128'(0));
  endtask

  task automatic t_stream();
    round_keys = expand_key(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    seq_len = 24;
    for (int i = 0; i < 24; i++) begin
      seq_vld[i] = 1'b1;
      case (i % 3)
        0: seq_dat[i] = {4{32'(i)}};
        1: seq_dat[i] = (i[0]) ? {16{8'haa}} : {16{8'h55}};
        default: seq_dat[i] = 128'h1 << (i * 5);
      endcase
    end
    run_seq("R7 back-to-back");
  endtask

  task automatic t_gaps();
    round_keys = expand_key(128'hffeeddccbbaa99887766554433221100);
    seq_len = 14;
    for (int i = 0; i < 14; i++) begin
      seq_vld[i] = (i % 3 != 1) && (i != 9);
      seq_dat[i] = {8{16'(i * 16'h1357 + 16'h2468)}};
    end
    run_seq("R8 gaps");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 idle valid", 128'(out_valid), 128'(0));
      check(out_block == last_ct, "R10 hold", out_block, last_ct);
      in_valid = 1'b0;
      in_block = {4{32'(i) * 32'h9e3779b9}};
    end
  endtask

  initial begin
    build_sbox();
    t_reset();
    // R1 R2 R3 R4 R5 R9: published vectors
    t_known(128'h000102030405060708090a0b0c0d0e0f,
            128'h00112233445566778899aabbccddeeff,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 R4 R9 vectorA");
    t_known(128'h2b7e151628aed2a6abf7158809cf4f3c,
            128'h3243f6a8885a308d313198a2e0370734,
            128'h3925841d02dc09fbdc118597196a0b32, "R3 R5 vectorB");
    t_known(128'h0, 128'h0,
            128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R2 zero-byte");
    t_stream();
    t_hold();
    t_gaps();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule